// File: doc/BRIEF.md
# I/O Slave Byte-Lane Steering

This block handles the data phase of a 32-bit multiplexed address/data bus when the device is the target of an I/O cycle. It looks at the active-low byte enables together with a mode input that selects 32-bit or 16-bit I/O operation, and at a flag telling whether the access falls in the address PROM region. From these it decides whether the access size is legal. For a legal read it places register data on the byte lanes, and it also puts copies of the active bytes into lanes that a plain lane multiplexer would leave empty. For a legal write it produces a per-byte write strobe and the masked write data for the register file.

Register address decoding happens outside this block. The register file supplies the addressed doubleword with each byte on its natural lane. The block registers its results, so each data phase shown at a clock edge appears on the outputs one cycle later. An access whose size is not allowed in the current mode or region is flagged. It returns all-zero read data and its write data is discarded. Lanes that carry nothing defined are driven to zero.

Top module: `io_lane_steer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge, even when an access is presented.
- R2: With `mode32`=1, only byte-enable pattern 4'b0000 is accepted. Every other pattern is rejected.
- R3: With `mode32`=0, pattern 4'b1100 (even half-word, lanes 0-1) and pattern 4'b0011 (odd half-word, lanes 2-3) are accepted whatever the region. Pattern 4'b0000 is rejected.
- R4: The single-byte patterns 4'b1110 (lane 0), 4'b1101 (lane 1), 4'b1011 (lane 2) and 4'b0111 (lane 3) are accepted only when `mode32`=0 and `prom_hit`=1. Pattern 4'b1111 and every pattern not named in R2 to R4 are rejected in both modes.
- R5: Accepted reads of full and half-word size behave as follows. 4'b0000 puts all four register bytes on their own lanes. 4'b1100 puts bytes 0-1 on lanes 0-1 and zero on lanes 2-3. 4'b0011 puts bytes 2-3 on lanes 2-3 and copies them onto lanes 0-1, so that `ad_out[15:0]` equals `ad_out[31:16]`.
- R6: An accepted single-byte read puts the addressed byte on its own lane and on the other lane of the same half-word. For a byte in the low half-word, lanes 2-3 are zero. For a byte in the upper half-word, the byte is also copied onto lanes 0 and 1.
- R7: Outputs change one clock after the access is presented. A cycle with `access_valid`=0 yields all-zero outputs.
- R8: On an accepted write, `ad_oe`=0 and `ad_out`=0. `wr_strb[i]` is the inverse of `be_n[i]`. `wr_data` carries `bus_wdata` on lanes whose strobe is set and zero on the other lanes.
- R9: A rejected access gives `access_err`=1, `access_ok`=0, `ad_out`=0, `wr_strb`=0 and `wr_data`=0. A read still drives `ad_oe`=1. An accepted access gives `access_ok`=1 and `access_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| access_valid | input | 1 | A data phase targets this device in this cycle |
| is_write | input | 1 | 1 for a write data phase, 0 for a read |
| mode32 | input | 1 | 1 selects 32-bit I/O mode, 0 selects 16-bit I/O mode |
| prom_hit | input | 1 | The access addresses the address PROM region |
| be_n | input | 4 | Active-low byte enables, bit i for lane i |
| reg_rdata | input | 32 | Addressed register doubleword, bytes on natural lanes |
| bus_wdata | input | 32 | Data lanes from the bus during a write |
| ad_out | output | 32 | Steered read data for the bus lanes |
| ad_oe | output | 1 | Drive enable for the data lanes (reads only) |
| wr_strb | output | 4 | Per-byte write strobe for the register file |
| wr_data | output | 32 | Masked write data for the register file |
| access_ok | output | 1 | The access was legal and was carried out |
| access_err | output | 1 | The access size was illegal for the mode or region |

## Verification
The hardest case to reach is an upper-half single-byte read. It is legal only in 16-bit mode inside the PROM region, and only then does the byte get mirrored into three other lanes. The bench reaches it by sweeping every byte-enable pattern against every mode, region and direction combination. Each lane of the read data carries a distinct byte value, so a copy taken from the wrong lane shows up. The same pattern outside the PROM region must give zero data.

// File: rtl/io_lane_pkg.sv
// Package: shared lane count and access classification types for the
// I/O slave byte-lane steering block. Assumes a four-lane data bus.
package io_lane_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_DWORD   = 3'd1,
        ACC_WORD_LO = 3'd2,
        ACC_WORD_HI = 3'd3,
        ACC_BYTE    = 3'd4
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic        legal;
        logic [1:0]  byte_idx;
    } acc_info_t;

endpackage

// File: rtl/io_be_classify.sv
// Module: io_be_classify
// Classifies an active-low byte-enable pattern into an access size and
// decides legality from the I/O width mode and the PROM region flag.
// Assumes four lanes; purely combinational.
module io_be_classify
    import io_lane_pkg::*;
(
    input  logic [LANES-1:0] be_n,
    input  logic             mode32,
    input  logic             prom_hit,
    output acc_info_t        info
);

    // Map the pattern to a size class, then gate legality by mode and region.
    always_comb begin
        info.kind     = ACC_NONE;
        info.legal    = 1'b0;
        info.byte_idx = 2'd0;
        case (be_n)
            4'b0000: begin
                info.kind  = ACC_DWORD;
                info.legal = mode32;
            end
            4'b1100: begin
                info.kind  = ACC_WORD_LO;
                info.legal = !mode32;
            end
            4'b0011: begin
                info.kind  = ACC_WORD_HI;
                info.legal = !mode32;
            end
            4'b1110: begin
                info.kind     = ACC_BYTE;
                info.byte_idx = 2'd0;
                info.legal    = !mode32 && prom_hit;
            end
            4'b1101: begin
                info.kind     = ACC_BYTE;
                info.byte_idx = 2'd1;
                info.legal    = !mode32 && prom_hit;
            end
            4'b1011: begin
                info.kind     = ACC_BYTE;
                info.byte_idx = 2'd2;
                info.legal    = !mode32 && prom_hit;
            end
            4'b0111: begin
                info.kind     = ACC_BYTE;
                info.byte_idx = 2'd3;
                info.legal    = !mode32 && prom_hit;
            end
            default: begin
                info.kind  = ACC_NONE;
                info.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/io_rd_lane_mux.sv
// Module: io_rd_lane_mux
// Builds the read-data lanes: each output lane picks a source byte of the
// register doubleword or zero. Upper-half accesses are mirrored into the
// low half and single bytes into their partner lane. Combinational.
module io_rd_lane_mux
    import io_lane_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  acc_info_t                info,
    input  logic [LANES*BYTE_W-1:0]  reg_rdata,
    output logic [LANES*BYTE_W-1:0]  rd_bus
);

    for (genvar g = 0; g < LANES; g++) begin : gen_lane
        localparam logic [1:0] LANE_ID = 2'(g);
        logic       lane_en;
        logic [1:0] lane_src;

        // Choose whether this lane is driven and from which source byte.
        always_comb begin
            lane_en  = 1'b0;
            lane_src = LANE_ID;
            case (info.kind)
                ACC_DWORD: begin
                    lane_en  = 1'b1;
                    lane_src = LANE_ID;
                end
                ACC_WORD_LO: begin
                    lane_en  = !LANE_ID[1];
                    lane_src = LANE_ID;
                end
                ACC_WORD_HI: begin
                    lane_en  = 1'b1;
                    lane_src = LANE_ID | 2'b10;
                end
                ACC_BYTE: begin
                    lane_en  = info.byte_idx[1] || !LANE_ID[1];
                    lane_src = info.byte_idx;
                end
                default: begin
                    lane_en  = 1'b0;
                    lane_src = LANE_ID;
                end
            endcase
            if (!info.legal) begin
                lane_en = 1'b0;
            end
        end

        // Drive the lane with the selected byte or zero.
        always_comb begin
            rd_bus[g*BYTE_W +: BYTE_W] = lane_en
                ? reg_rdata[lane_src*BYTE_W +: BYTE_W]
                : '0;
        end
    end

endmodule

// File: rtl/io_wr_lane_mask.sv
// Module: io_wr_lane_mask
// Derives per-byte write strobes from the byte enables and masks the write
// lanes so that inactive lanes read as zero. Illegal accesses strobe nothing.
module io_wr_lane_mask
    import io_lane_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [LANES-1:0]         be_n,
    input  logic                     legal,
    input  logic [LANES*BYTE_W-1:0]  bus_wdata,
    output logic [LANES-1:0]         strb,
    output logic [LANES*BYTE_W-1:0]  wdata_masked
);

    for (genvar g = 0; g < LANES; g++) begin : gen_lane
        // Strobe a lane when the access is legal and its enable is active.
        always_comb begin
            strb[g] = legal && !be_n[g];
        end

        // Pass the bus byte only on strobed lanes.
        always_comb begin
            wdata_masked[g*BYTE_W +: BYTE_W] = strb[g]
                ? bus_wdata[g*BYTE_W +: BYTE_W]
                : '0;
        end
    end

endmodule

// File: rtl/io_lane_steer.sv
// Module: io_lane_steer (top)
// Data-phase handler for I/O target accesses on a multiplexed 32-bit bus.
// Classifies the byte enables, steers read data with lane copies, masks
// write data, and registers all results one cycle after the data phase.
// Assumes the register file presents the addressed doubleword on reg_rdata
// in the same cycle as access_valid.
module io_lane_steer
    import io_lane_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    access_valid,
    input  logic                    is_write,
    input  logic                    mode32,
    input  logic                    prom_hit,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*BYTE_W-1:0] reg_rdata,
    input  logic [LANES*BYTE_W-1:0] bus_wdata,
    output logic [LANES*BYTE_W-1:0] ad_out,
    output logic                    ad_oe,
    output logic [LANES-1:0]        wr_strb,
    output logic [LANES*BYTE_W-1:0] wr_data,
    output logic                    access_ok,
    output logic                    access_err
);

    localparam int unsigned DATA_W = LANES * BYTE_W;

    acc_info_t          info;
    logic [DATA_W-1:0]  rd_bus;
    logic [LANES-1:0]   strb_c;
    logic [DATA_W-1:0]  wdata_c;

    io_be_classify u_classify (
        .be_n     (be_n),
        .mode32   (mode32),
        .prom_hit (prom_hit),
        .info     (info)
    );

    io_rd_lane_mux #(.BYTE_W(BYTE_W)) u_rd_mux (
        .info      (info),
        .reg_rdata (reg_rdata),
        .rd_bus    (rd_bus)
    );

    io_wr_lane_mask #(.BYTE_W(BYTE_W)) u_wr_mask (
        .be_n         (be_n),
        .legal        (info.legal),
        .bus_wdata    (bus_wdata),
        .strb         (strb_c),
        .wdata_masked (wdata_c)
    );

    // Register the steered results of the data phase; idle cycles clear them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_out     <= '0;
            ad_oe      <= 1'b0;
            wr_strb    <= '0;
            wr_data    <= '0;
            access_ok  <= 1'b0;
            access_err <= 1'b0;
        end else if (access_valid) begin
            ad_out     <= is_write ? '0 : rd_bus;
            ad_oe      <= !is_write;
            wr_strb    <= is_write ? strb_c : '0;
            wr_data    <= is_write ? wdata_c : '0;
            access_ok  <= info.legal;
            access_err <= !info.legal;
        end else begin
            ad_out     <= '0;
            ad_oe      <= 1'b0;
            wr_strb    <= '0;
            wr_data    <= '0;
            access_ok  <= 1'b0;
            access_err <= 1'b0;
        end
    end

endmodule

// File: rtl/io_lane_steer_chk.sv
// Module: io_lane_steer_chk
// Property checker for io_lane_steer, attached by bind. Relates the inputs
// of a data phase to the registered outputs one cycle later.
module io_lane_steer_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  access_valid,
    input  logic                  is_write,
    input  logic                  mode32,
    input  logic                  prom_hit,
    input  logic [3:0]            be_n,
    input  logic [4*BYTE_W-1:0]   ad_out,
    input  logic                  ad_oe,
    input  logic [3:0]            wr_strb,
    input  logic [4*BYTE_W-1:0]   wr_data,
    input  logic                  access_ok,
    input  logic                  access_err
);

    p_ok_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({access_ok, access_err}));

    p_full_only_mode32_r2: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && mode32 && (be_n != 4'b0000) |=> access_err);

    p_no_full_mode16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && !mode32 && (be_n == 4'b0000) |=> access_err);

    p_byte_needs_prom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && !prom_hit && ($countones(~be_n) == 1) |=> access_err);

    p_hi_word_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && !is_write && (be_n == 4'b0011)
        |=> ad_out[2*BYTE_W-1:0] == ad_out[4*BYTE_W-1:2*BYTE_W]);

    p_lo_byte_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && !is_write && ((be_n == 4'b1110) || (be_n == 4'b1101))
        |=> (ad_out[2*BYTE_W-1:BYTE_W] == ad_out[BYTE_W-1:0])
            && (ad_out[4*BYTE_W-1:2*BYTE_W] == '0));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !access_valid |=> !ad_oe && (wr_strb == '0) && !access_ok && !access_err);

    p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access_valid && is_write |=> !ad_oe && (ad_out == '0));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> (ad_out == '0) && (wr_strb == '0) && (wr_data == '0));

endmodule

bind io_lane_steer io_lane_steer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .access_valid (access_valid),
    .is_write     (is_write),
    .mode32       (mode32),
    .prom_hit     (prom_hit),
    .be_n         (be_n),
    .ad_out       (ad_out),
    .ad_oe        (ad_oe),
    .wr_strb      (wr_strb),
    .wr_data      (wr_data),
    .access_ok    (access_ok),
    .access_err   (access_err)
);

// File: tb/test_io_lane_steer.sv
`timescale 1ns/1ps
// Bench for io_lane_steer: a behavioural model predicts every cycle's
// outputs, pushes them on a queue, and each clock the oldest prediction is
// compared at the falling edge.
module test_io_lane_steer;

    typedef struct {
        logic [31:0] ad;
        logic        oe;
        logic [3:0]  strb;
        logic [31:0] wdat;
        logic        ok;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        access_valid = 1'b0;
    logic        is_write = 1'b0;
    logic        mode32 = 1'b0;
    logic        prom_hit = 1'b0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] reg_rdata = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [3:0]  wr_strb;
    logic [31:0] wr_data;
    logic        access_ok;
    logic        access_err;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    io_lane_steer i_io_lane_steer (
        .clk(clk), .rst_n(rst_n), .access_valid(access_valid),
        .is_write(is_write), .mode32(mode32), .prom_hit(prom_hit),
        .be_n(be_n), .reg_rdata(reg_rdata), .bus_wdata(bus_wdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .wr_strb(wr_strb),
        .wr_data(wr_data), .access_ok(access_ok), .access_err(access_err)
    );

    // Behavioural prediction of the outputs after one clock edge.
    function automatic exp_t model(bit rst, bit v, bit wr, logic [3:0] be,
                                   bit m32, bit prom, logic [31:0] rd,
                                   logic [31:0] wd, string tag);
        exp_t e;
        int   active = 0;
        int   only = 0;
        bit   legal;
        e.ad = '0; e.oe = 0; e.strb = '0; e.wdat = '0; e.ok = 0; e.err = 0;
        e.tag = tag;
        if (!rst || !v) return e;
        for (int j = 0; j < 4; j++) begin
            if (!be[j]) begin
                active++;
                only = j;
            end
        end
        if (m32)                               legal = (be == 4'b0000);
        else if (be == 4'b1100 || be == 4'b0011) legal = 1;
        else if (active == 1)                  legal = prom;
        else                                   legal = 0;
        e.ok  = legal;
        e.err = !legal;
        if (wr) begin
            if (legal) begin
                e.strb = ~be;
                for (int j = 0; j < 4; j++)
                    if (!be[j]) e.wdat[8*j +: 8] = wd[8*j +: 8];
            end
        end else begin
            e.oe = 1;
            if (legal) begin
                for (int j = 0; j < 4; j++)
                    if (!be[j]) e.ad[8*j +: 8] = rd[8*j +: 8];
                if (active == 1) e.ad[8*(only ^ 1) +: 8] = rd[8*only +: 8];
                if (be[1:0] == 2'b11 && be[3:2] != 2'b11)
                    e.ad[15:0] = e.ad[31:16];
            end
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (ad_out !== e.ad || ad_oe !== e.oe || wr_strb !== e.strb ||
            wr_data !== e.wdat || access_ok !== e.ok || access_err !== e.err) begin
            errors++;
            $display("FAIL %s: actual ad=%h oe=%b strb=%b wd=%h ok=%b err=%b expected ad=%h oe=%b strb=%b wd=%h ok=%b err=%b",
                     e.tag, ad_out, ad_oe, wr_strb, wr_data, access_ok, access_err,
                     e.ad, e.oe, e.strb, e.wdat, e.ok, e.err);
        end
    endtask

    // Present one cycle of stimulus, then compare one clock later.
    task automatic step(bit rst, bit v, bit wr, logic [3:0] be, bit m32,
                        bit prom, logic [31:0] rd, logic [31:0] wd, string tag);
        rst_n = rst; access_valid = v; is_write = wr; be_n = be;
        mode32 = m32; prom_hit = prom; reg_rdata = rd; bus_wdata = wd;
        q.push_back(model(rst, v, wr, be, m32, prom, rd, wd, tag));
        @(posedge clk);
        @(negedge clk);
        compare(q.pop_front());
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset with an access presented gives zero outputs
        step(0, 1, 0, 4'b0000, 1, 0, 32'hA1B2C3D4, 32'h0, "R1");
        step(0, 1, 1, 4'b0000, 1, 0, 32'h0, 32'h55AA55AA, "R1");
        // R2: 32-bit mode full read, then rejected half-word
        step(1, 1, 0, 4'b0000, 1, 0, 32'h44332211, 32'h0, "R2");
        step(1, 1, 0, 4'b1100, 1, 1, 32'h44332211, 32'h0, "R2");
        // R3: 16-bit mode half-words in and out of PROM, full rejected
        step(1, 1, 0, 4'b1100, 0, 0, 32'h88776655, 32'h0, "R3");
        step(1, 1, 0, 4'b0011, 0, 0, 32'h88776655, 32'h0, "R3");
        step(1, 1, 0, 4'b0000, 0, 1, 32'h88776655, 32'h0, "R3");
        // R4: single byte needs PROM region and 16-bit mode; 1111 rejected
        step(1, 1, 0, 4'b1110, 0, 0, 32'hDDCCBBAA, 32'h0, "R4");
        step(1, 1, 0, 4'b1110, 1, 1, 32'hDDCCBBAA, 32'h0, "R4");
        step(1, 1, 0, 4'b1111, 0, 1, 32'hDDCCBBAA, 32'h0, "R4");
        // R5: half-word mirroring into the low lanes
        step(1, 1, 0, 4'b0011, 0, 1, 32'hCAFEF00D, 32'h0, "R5");
        // R6: each single byte with its copies
        step(1, 1, 0, 4'b1110, 0, 1, 32'h0D0C0B0A, 32'h0, "R6");
        step(1, 1, 0, 4'b1101, 0, 1, 32'h0D0C0B0A, 32'h0, "R6");
        step(1, 1, 0, 4'b1011, 0, 1, 32'h0D0C0B0A, 32'h0, "R6");
        step(1, 1, 0, 4'b0111, 0, 1, 32'h0D0C0B0A, 32'h0, "R6");
        // R7: idle cycles between accesses return to zero
        step(1, 0, 0, 4'b0000, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R7");
        step(1, 1, 0, 4'b0000, 1, 0, 32'h12345678, 32'h0, "R7");
        step(1, 0, 1, 4'b0000, 1, 0, 32'h12345678, 32'hFFFFFFFF, "R7");
        // R8: writes strobe active lanes only
        step(1, 1, 1, 4'b0000, 1, 0, 32'hFFFFFFFF, 32'h11223344, "R8");
        step(1, 1, 1, 4'b0011, 0, 0, 32'hFFFFFFFF, 32'h11223344, "R8");
        step(1, 1, 1, 4'b1011, 0, 1, 32'hFFFFFFFF, 32'h11223344, "R8");
        // R9: rejected write discards data
        step(1, 1, 1, 4'b0111, 0, 0, 32'h0, 32'hDEADBEEF, "R9");
        step(1, 1, 1, 4'b0101, 0, 1, 32'h0, 32'hDEADBEEF, "R9");
        // Sweep: every pattern, mode, region and direction (R2 R3 R4 R5 R6 R8 R9)
        for (int k = 0; k < 128; k++) begin
            logic [3:0] b;
            b = 4'(k);
            step(1, 1, k[6], b, k[4], k[5], 32'h40302010 + 32'(k),
                 32'h0A0B0C0D ^ 32'(k * 7), "R9-sweep");
        end
        // R1: reset asserted mid-run clears outputs on the next edge
        step(1, 1, 0, 4'b0000, 1, 0, 32'h99999999, 32'h0, "R1");
        step(0, 1, 0, 4'b0000, 1, 0, 32'h99999999, 32'h0, "R1");
        step(1, 0, 0, 4'b1111, 0, 0, 32'h0, 32'h0, "R7");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule